// File: doc/BRIEF.md
# Instruction-Driven Serial Register Port

This block is a synchronous serial slave. It lets a host reach a small internal register file over three wires: a serial clock, an active-low select and a half-duplex data line. The data line is split here into an input, an output and an output enable. The host opens each exchange with one instruction byte. That byte gives the direction, a byte count of one to three and a 4-bit starting byte address. The block then moves that many data bytes, and after each byte it steps the address by one, upward or downward.

The serial pins are sampled by the block's own system clock through synchronisers, and clock edges are found by comparing successive samples. All register contents appear as parallel outputs for neighbouring logic. Writes to the command register go to a shadow copy. The whole shadow is copied into the live command register in one step, on the falling serial-clock edge that ends the write transaction. An exchange cut short by select does not change the live command register.

The controller has five states. `ST_IDLE` waits for select. `ST_INSTR` shifts in the instruction byte. `ST_WRITE` and `ST_READ` move data bytes. `ST_COMMIT` waits for the closing falling edge after a write that touched the command register. The transitions are:
- Select low moves `ST_IDLE` to `ST_INSTR`.
- A completed instruction moves `ST_INSTR` to `ST_WRITE` or `ST_READ`, according to its top bit.
- The last data byte returns `ST_WRITE` and `ST_READ` to `ST_INSTR`, or moves `ST_WRITE` to `ST_COMMIT` if a command byte was staged.
- The falling edge moves `ST_COMMIT` to `ST_INSTR`.
- Select high sends every state to `ST_IDLE`.

Top module: `serial_reg_port`

## Requirements
- R1: The instruction is shifted in MSB first, one bit per rising serial-clock edge. Bit 7 set means read and clear means write. Bits 6:5 give the byte count: 00 is one byte, 01 is two, 10 is three, and 11 is treated as one. Bits 3:0 give the starting byte address.
- R2: The byte map is as follows. 0 and 1 hold the 16-bit data word, high byte at 0. 4 and 5 hold the 16-bit command word, high byte at 4. 8, 9 and 10 hold the 24-bit offset word, high byte first. 12, 13 and 14 hold the 24-bit full-scale word, high byte first. A written byte shows on the parallel outputs once its eighth rising edge has been seen.
- R3: Addresses 2, 3, 6, 7, 11 and 15 are reserved. Writes to them change nothing, and reads from them return zero.
- R4: When command bit 2 is clear, the address rises by one after every data byte, wrapping modulo 16.
- R5: When command bit 2 is set, the address falls by one after every data byte of a read, and of a write to a non-command byte.
- R6: While a write transaction sits on a command byte (address 4 or 5), the next address is always one higher, whatever bit 2 holds.
- R7: A command write becomes visible all at once, on the falling serial-clock edge of the last bit of the transaction's last byte. Until that edge the previous command value stays on the output.
- R8: Raising select aborts any partial transaction. Staged command bytes are dropped. Non-command bytes that were fully received before the abort stay written.
- R9: Read bits are driven MSB first after falling serial-clock edges. The output enable is high only during the data bytes of a read, and it goes low once select is raised.
- R10: Once the counted bytes have moved, the next byte under the same select is decoded as a new instruction.
- R11: After reset, all registers read zero and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| sdio_in | input | 1 | Serial data from the host |
| sdio_out | output | 1 | Serial read data to the host |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| data_reg | output | 16 | Data word |
| cmd_reg | output | 16 | Live command word (bit 2 selects downward stepping) |
| ofs_reg | output | 24 | Offset word |
| fs_reg | output | 24 | Full-scale word |

## Verification
The bench sweeps every starting address with every count code, once with upward stepping and once with downward stepping. After each write it compares the parallel outputs with an arithmetic model, and after each read it compares every returned byte with the same model.
- A wrong step direction or a missing wrap misplaces bytes at the edges of the map.
- A reserved address that is not decoded leaks nonzero read data.
- A design that applies the direction bit to command writes splits a two-byte command write across addresses 4 and 3.

Directed cases cover the rest:
- The command word is checked while the serial clock is held high after the last bit, and again after the closing fall. An early commit shows up on the first check.
- Select is raised after a single staged command byte. A design that commits partial updates changes the command output.
- The code-11 write is followed by a read instruction under the same select. A design that mistakes the count would absorb the second instruction as data.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 16;
    localparam int CMD_W     = 16;
    localparam int CAL_BYTES = 3;
    localparam int CAL_W     = CAL_BYTES * BYTE_W;
    localparam int CAL_BANKS = 2;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    // Command word field positions
    localparam int CMD_STEP_DOWN_BIT = 2;

    // Byte map
    localparam logic [ADDR_W-1:0] A_DATA_HI = 4'd0;
    localparam logic [ADDR_W-1:0] A_DATA_LO = 4'd1;
    localparam logic [ADDR_W-1:0] A_CMD_HI  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CMD_LO  = 4'd5;
    localparam int               CAL_BASE_BANK = 2;   // address bits 3:2 of bank 0

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WRITE,
        ST_READ,
        ST_COMMIT
    } srp_state_e;

    typedef struct packed {
        logic              is_read;
        logic [1:0]        count;
        logic              pad;
        logic [ADDR_W-1:0] addr;
    } srp_instr_t;

    // Bytes still to move after the first one
    function automatic logic [1:0] extra_bytes(input logic [1:0] code);
        unique case (code)
            2'b01:   extra_bytes = 2'd1;
            2'b10:   extra_bytes = 2'd2;
            default: extra_bytes = 2'd0;
        endcase
    endfunction

    function automatic logic is_cmd_addr(input logic [ADDR_W-1:0] a);
        is_cmd_addr = (a == A_CMD_HI) || (a == A_CMD_LO);
    endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel,
    output logic sdi_s
);
    // Each stage holds {sclk, select active, data}
    localparam logic [2:0] IDLE_PINS = 3'b000;

    logic [STAGES-1:0][2:0] stg_q;
    logic                   sclk_prev_q;
    logic [2:0]             last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q       <= {STAGES{IDLE_PINS}};
            sclk_prev_q <= 1'b0;
        end else begin
            stg_q       <= {stg_q[STAGES-2:0], {sclk, ~cs_n, sdi}};
            sclk_prev_q <= last[2];
        end
    end

    assign last      = stg_q[STAGES-1];
    assign sclk_rise = last[2] & ~sclk_prev_q;
    assign sclk_fall = ~last[2] & sclk_prev_q;
    assign sel       = last[1];
    assign sdi_s     = last[0];

endmodule

// File: rtl/srp_regs.sv
module srp_regs
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              shadow_load,
    input  logic              commit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [DATA_W-1:0] data_reg,
    output logic [CMD_W-1:0]  cmd_reg,
    output logic [CAL_W-1:0]  ofs_reg,
    output logic [CAL_W-1:0]  fs_reg
);
    logic [DATA_W-1:0] data_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [CMD_W-1:0]  cmd_sh_q;

    logic [CAL_BANKS-1:0][CAL_W-1:0]  cal_word;
    logic [CAL_BANKS-1:0][BYTE_W-1:0] cal_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_DATA_HI) data_q[15:8] <= wr_byte;
            if (wr_addr == A_DATA_LO) data_q[7:0]  <= wr_byte;
        end
    end

    // Command bytes are staged and copied to the live word in one step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            cmd_sh_q <= '0;
        end else begin
            if (shadow_load) begin
                cmd_sh_q <= cmd_q;
            end else if (wr_en) begin
                if (wr_addr == A_CMD_HI) cmd_sh_q[15:8] <= wr_byte;
                if (wr_addr == A_CMD_LO) cmd_sh_q[7:0]  <= wr_byte;
            end
            if (commit) cmd_q <= cmd_sh_q;
        end
    end

    // Two identical three-byte calibration banks
    for (genvar b = 0; b < CAL_BANKS; b++) begin : g_cal
        logic [CAL_W-1:0] q;
        logic             wr_hit;
        logic             rd_hit;

        assign wr_hit = wr_en && (wr_addr[3:2] == 2'(b + CAL_BASE_BANK))
                        && (wr_addr[1:0] != 2'b11);
        assign rd_hit = (rd_addr[3:2] == 2'(b + CAL_BASE_BANK))
                        && (rd_addr[1:0] != 2'b11);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_hit) begin
                unique case (wr_addr[1:0])
                    2'd0:    q[23:16] <= wr_byte;
                    2'd1:    q[15:8]  <= wr_byte;
                    default: q[7:0]   <= wr_byte;
                endcase
            end
        end

        always_comb begin
            cal_rd[b] = '0;
            if (rd_hit) begin
                unique case (rd_addr[1:0])
                    2'd0:    cal_rd[b] = q[23:16];
                    2'd1:    cal_rd[b] = q[15:8];
                    default: cal_rd[b] = q[7:0];
                endcase
            end
        end

        assign cal_word[b] = q;
    end

    always_comb begin
        rd_byte = '0;
        unique case (rd_addr)
            A_DATA_HI: rd_byte = data_q[15:8];
            A_DATA_LO: rd_byte = data_q[7:0];
            A_CMD_HI:  rd_byte = cmd_q[15:8];
            A_CMD_LO:  rd_byte = cmd_q[7:0];
            default: begin
                for (int b = 0; b < CAL_BANKS; b++) rd_byte = rd_byte | cal_rd[b];
            end
        endcase
    end

    assign data_reg = data_q;
    assign cmd_reg  = cmd_q;
    assign ofs_reg  = cal_word[0];
    assign fs_reg   = cal_word[1];

endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sel,
    input  logic              sdi,
    input  logic              step_down_cfg,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              shadow_load,
    output logic              commit,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sdo,
    output logic              oe
);
    srp_state_e state_q, state_d;

    logic [BYTE_W-1:0]    shift_q;
    logic [BIT_CNT_W-1:0] bit_q;
    logic [1:0]           left_q;
    logic [ADDR_W-1:0]    addr_q;
    logic                 touched_q;
    logic [BYTE_W-1:0]    tx_q;
    logic                 sdo_q;
    logic                 oe_q;

    logic [BYTE_W-1:0] in_byte;
    srp_instr_t        instr;
    logic              active;
    logic              byte_done;
    logic              cmd_here;
    logic              go_down;
    logic [ADDR_W-1:0] step_addr;

    assign in_byte   = {shift_q[BYTE_W-2:0], sdi};
    assign instr     = srp_instr_t'(in_byte);
    assign active    = (state_q == ST_INSTR) || (state_q == ST_WRITE) || (state_q == ST_READ);
    assign byte_done = sel && active && sclk_rise && (bit_q == BIT_CNT_W'(BYTE_W - 1));
    assign cmd_here  = is_cmd_addr(addr_q);
    assign go_down   = step_down_cfg && !((state_q == ST_WRITE) && cmd_here);
    assign step_addr = go_down ? addr_q - 1'b1 : addr_q + 1'b1;

    assign rd_addr     = (state_q == ST_INSTR) ? instr.addr : step_addr;
    assign wr_en       = byte_done && (state_q == ST_WRITE);
    assign wr_addr     = addr_q;
    assign wr_byte     = in_byte;
    assign shadow_load = byte_done && (state_q == ST_INSTR);
    assign commit      = sel && sclk_fall && (state_q == ST_COMMIT);
    assign sdo         = sdo_q;
    assign oe          = oe_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!sel) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_INSTR;
                ST_INSTR:  if (byte_done) state_d = instr.is_read ? ST_READ : ST_WRITE;
                ST_WRITE:  if (byte_done && left_q == 2'd0)
                               state_d = (touched_q || cmd_here) ? ST_COMMIT : ST_INSTR;
                ST_READ:   if (byte_done && left_q == 2'd0) state_d = ST_INSTR;
                ST_COMMIT: if (sclk_fall) state_d = ST_INSTR;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q   <= '0;
            bit_q     <= '0;
            left_q    <= '0;
            addr_q    <= '0;
            touched_q <= 1'b0;
            tx_q      <= '0;
            sdo_q     <= 1'b0;
            oe_q      <= 1'b0;
        end else if (!sel) begin
            bit_q     <= '0;
            touched_q <= 1'b0;
            oe_q      <= 1'b0;
        end else begin
            if (active && sclk_rise) begin
                shift_q <= in_byte;
                bit_q   <= bit_q + 1'b1;
            end
            if (byte_done) begin
                if (state_q == ST_INSTR) begin
                    left_q    <= extra_bytes(instr.count);
                    addr_q    <= instr.addr;
                    touched_q <= 1'b0;
                    if (instr.is_read) tx_q <= rd_byte;
                end else begin
                    left_q <= left_q - 1'b1;
                    addr_q <= step_addr;
                    if (state_q == ST_WRITE && cmd_here) touched_q <= 1'b1;
                    if (state_q == ST_READ && left_q != 2'd0) tx_q <= rd_byte;
                end
            end
            if (sclk_fall) begin
                if (state_q == ST_READ) begin
                    sdo_q <= tx_q[BYTE_W-1];
                    tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                    oe_q  <= 1'b1;
                end else begin
                    oe_q  <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import srp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic [DATA_W-1:0] data_reg,
    output logic [CMD_W-1:0]  cmd_reg,
    output logic [CAL_W-1:0]  ofs_reg,
    output logic [CAL_W-1:0]  fs_reg
);
    logic              sclk_rise;
    logic              sclk_fall;
    logic              sel;
    logic              sdi_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_byte;
    logic              shadow_load;
    logic              cmd_commit;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rd_byte;

    srp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdio_in),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sel       (sel),
        .sdi_s     (sdi_s)
    );

    srp_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk_rise     (sclk_rise),
        .sclk_fall     (sclk_fall),
        .sel           (sel),
        .sdi           (sdi_s),
        .step_down_cfg (cmd_reg[CMD_STEP_DOWN_BIT]),
        .rd_byte       (rd_byte),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_byte       (wr_byte),
        .shadow_load   (shadow_load),
        .commit        (cmd_commit),
        .rd_addr       (rd_addr),
        .sdo           (sdio_out),
        .oe            (sdio_oe)
    );

    srp_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_byte     (wr_byte),
        .shadow_load (shadow_load),
        .commit      (cmd_commit),
        .rd_addr     (rd_addr),
        .rd_byte     (rd_byte),
        .data_reg    (data_reg),
        .cmd_reg     (cmd_reg),
        .ofs_reg     (ofs_reg),
        .fs_reg      (fs_reg)
    );

endmodule

// File: rtl/srp_checker.sv
module srp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic        sclk_rise,
    input logic        sclk_fall,
    input logic        cmd_commit,
    input logic        sdio_oe,
    input logic [15:0] data_reg,
    input logic [15:0] cmd_reg,
    input logic [23:0] ofs_reg,
    input logic [23:0] fs_reg
);
    p_oe_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !sdio_oe);

    p_oe_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> $past(sclk_fall));

    p_cmd_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_commit |=> $stable(cmd_reg));

    p_cmd_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_reg) |-> $past(sclk_fall));

    p_word_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable({data_reg, ofs_reg, fs_reg}));

    p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable({data_reg, cmd_reg, ofs_reg, fs_reg}));

endmodule

bind serial_reg_port srp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .cmd_commit (cmd_commit),
    .sdio_oe    (sdio_oe),
    .data_reg   (data_reg),
    .cmd_reg    (cmd_reg),
    .ofs_reg    (ofs_reg),
    .fs_reg     (fs_reg)
);

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe;
    logic [15:0] data_reg, cmd_reg;
    logic [23:0] ofs_reg, fs_reg;

    always #4 clk = ~clk;

    serial_reg_port u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .data_reg(data_reg),
        .cmd_reg(cmd_reg), .ofs_reg(ofs_reg), .fs_reg(fs_reg)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  m [16];
    logic [15:0] mc;
    logic [7:0]  wbuf [4];
    logic [7:0]  ebuf [4];
    logic [7:0]  rbuf [4];
    logic [3:0]  abuf [4];

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic is_res(input logic [3:0] a);
        return (a == 2) || (a == 3) || (a == 6) || (a == 7) || (a == 11) || (a == 15);
    endfunction

    function automatic logic [7:0] mread(input logic [3:0] a);
        if (a == 4) return mc[15:8];
        if (a == 5) return mc[7:0];
        if (is_res(a)) return 8'h00;
        return m[a];
    endfunction

    function automatic int nbytes(input logic [1:0] code);
        return (code == 2'b01) ? 2 : (code == 2'b10) ? 3 : 1;
    endfunction

    // Requirement model: fills abuf/ebuf; applies writes unless dry
    task automatic model_xfer(input logic rd, input logic dry, input logic [1:0] code,
                              input logic [3:0] start);
        logic [3:0]  a;
        logic [15:0] sh;
        logic        touched;
        logic        dn;
        a = start; sh = mc; touched = 1'b0;
        for (int k = 0; k < nbytes(code); k++) begin
            abuf[k] = a;
            if (rd) ebuf[k] = mread(a);
            else if (!dry) begin
                if (a == 4) begin sh[15:8] = wbuf[k]; touched = 1'b1; end
                else if (a == 5) begin sh[7:0] = wbuf[k]; touched = 1'b1; end
                else if (!is_res(a)) m[a] = wbuf[k];
            end
            dn = mc[2] && !(!rd && (a == 4 || a == 5));
            a  = dn ? a - 4'd1 : a + 4'd1;
        end
        if (touched && !dry) mc = sh;
    endtask

    task automatic chk_outs(input string req);
        check(req, {data_reg, cmd_reg, ofs_reg, fs_reg},
              {m[0], m[1], mc, m[8], m[9], m[10], m[12], m[13], m[14]});
    endtask

    task automatic do_byte(input logic [7:0] tx, input logic exp_oe, input logic end_low,
                           output logic [7:0] rx, output logic oe_ok);
        oe_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sdio_in = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = sdio_out;
            if (sdio_oe !== exp_oe) oe_ok = 1'b0;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (i > 0 || end_low) sclk = 1'b0;
        end
    endtask

    task automatic xact(input logic rd, input logic [1:0] code, input logic [3:0] a);
        logic ok;
        logic [7:0] dum;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        do_byte({rd, code, 1'b0, a}, 1'b0, 1'b1, dum, ok);
        check("R9 oe low in instruction", ok, 1);
        for (int k = 0; k < nbytes(code); k++) begin
            do_byte(rd ? 8'h00 : wbuf[k], rd, 1'b1, rbuf[k], ok);
            check("R9 oe during data", ok, 1);
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        check("R9 oe released", sdio_oe, 0);
    endtask

    task automatic run_write(input logic [1:0] code, input logic [3:0] a, input logic [7:0] seed);
        logic res;
        model_xfer(1'b0, 1'b1, code, a);
        res = 1'b0;
        for (int k = 0; k < nbytes(code); k++) begin
            wbuf[k] = seed + 8'(k * 37);
            if (abuf[k] == 5) wbuf[k][2] = mc[2];
            if (is_res(abuf[k])) res = 1'b1;
        end
        model_xfer(1'b0, 1'b0, code, a);
        xact(1'b0, code, a);
        chk_outs(res ? "R3 reserved write ignored" : "R2 write map");
    endtask

    task automatic run_read(input logic [1:0] code, input logic [3:0] a);
        model_xfer(1'b1, 1'b0, code, a);
        xact(1'b1, code, a);
        for (int k = 0; k < nbytes(code); k++) begin
            if (is_res(abuf[k]))      check("R3 reserved read", rbuf[k], ebuf[k]);
            else if (code == 2'b11)   check("R1 count code 11", rbuf[k], ebuf[k]);
            else if (mc[2])           check("R5 step down read", rbuf[k], ebuf[k]);
            else                      check("R4 step up read", rbuf[k], ebuf[k]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        logic ok;
        for (int i = 0; i < 16; i++) m[i] = 8'h00;
        mc = 16'h0000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk_outs("R11 reset registers");
        check("R11 reset oe", sdio_oe, 0);

        for (int dir = 0; dir < 2; dir++) begin
            wbuf[0] = 8'h00;
            wbuf[1] = (dir != 0) ? 8'h04 : 8'h00;
            model_xfer(1'b0, 1'b0, 2'b01, 4'd4);
            xact(1'b0, 2'b01, 4'd4);
            chk_outs("R6 command write");
            for (int a = 0; a < 16; a++) begin
                for (int c = 0; c < 4; c++) begin
                    run_write(2'(c), 4'(a), 8'(a * 16 + c * 5 + dir * 99 + 1));
                    run_read(2'(c), 4'(a));
                end
            end
        end

        // R6: stepping down is active, command write still goes 4 then 5
        wbuf[0] = 8'hA5; wbuf[1] = 8'h04;
        model_xfer(1'b0, 1'b0, 2'b01, 4'd4);
        xact(1'b0, 2'b01, 4'd4);
        chk_outs("R6 command write upward");
        check("R6 command value", cmd_reg, 16'hA504);

        // R7: commit waits for the closing falling edge
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        do_byte({1'b0, 2'b00, 1'b0, 4'd5}, 1'b0, 1'b1, rx, ok);
        do_byte(8'h00, 1'b0, 1'b0, rx, ok);
        repeat (10) @(negedge clk);
        check("R7 old command before fall", cmd_reg, mc);
        sclk = 1'b0;
        repeat (10) @(negedge clk);
        mc[7:0] = 8'h00;
        check("R7 new command after fall", cmd_reg, mc);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);

        // R8: abort after one staged command byte
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        do_byte({1'b0, 2'b01, 1'b0, 4'd4}, 1'b0, 1'b1, rx, ok);
        do_byte(8'hFF, 1'b0, 1'b1, rx, ok);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        check("R8 aborted command not committed", cmd_reg, mc);

        // R8: a complete data byte stays, the partial one is dropped
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        do_byte({1'b0, 2'b01, 1'b0, 4'd0}, 1'b0, 1'b1, rx, ok);
        do_byte(8'h12, 1'b0, 1'b1, rx, ok);
        for (int i = 0; i < 3; i++) begin
            sdio_in = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        m[0] = 8'h12;
        chk_outs("R8 partial transaction");

        // R1 and R10: code 11 moves one byte, next byte is an instruction
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        do_byte({1'b0, 2'b11, 1'b0, 4'd8}, 1'b0, 1'b1, rx, ok);
        do_byte(8'h3C, 1'b0, 1'b1, rx, ok);
        do_byte({1'b1, 2'b00, 1'b0, 4'd8}, 1'b0, 1'b1, rx, ok);
        do_byte(8'h00, 1'b1, 1'b1, rx, ok);
        check("R10 read after back-to-back instruction", rx, 8'h3C);
        check("R9 oe in chained read", ok, 1);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        m[8] = 8'h3C;
        chk_outs("R1 count code 11 single byte");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule